// File: doc/BRIEF.md
# ULPI Register Viewport Engine

This block lets software reach the registers of an external USB transceiver over the ULPI link through a single command word. Software places a command on the viewport: a run flag, a read/write select, a six-bit register address and a write byte. If the engine is idle and the run flag is set, it takes the command and carries out one ULPI register cycle. It drives the transmit command byte, waits for the transceiver to accept it, and then either sends the data byte and closes with STP or turns the bus around and captures the returned byte.

The run flag stays set until the cycle is over and then clears by itself, so software can poll it. The byte from a read remains available on the read-data output. A software timeout is supported by a stall flag that rises once the run flag has been set for a parameterised number of clocks. A synchronous link reset drops any transfer in progress so that the engine accepts a new command. A separate stop-force control holds STP high for as long as it is set, which blocks transceiver traffic during low-power entry.

Top module: `ulpi_vp_engine`

## Requirements
- R1: After reset, vp_run_o, ulpi_data_oe_o, ulpi_stp_o, stall_o and vp_rdata_o are all 0.
- R2: A cmd_we_i pulse with cmd_run_i=1 while vp_run_o=0 starts an operation, and vp_run_o reads 1 on the next clock. A pulse with cmd_run_i=0 starts nothing.
- R3: While the command is pending and ulpi_dir_i=0, the engine drives the transmit command byte with the output enable high. Bits [7:6] are 2'b10 for a register write and 2'b11 for a register read, and bits [5:0] carry the address.
- R4: Write cycle: on the clock after ulpi_nxt_i is seen high with the command byte, the engine drives the write byte. On the following clock it drives 0 with STP high. On the clock after that, vp_run_o clears and the bus is released.
- R5: Read cycle: after ulpi_nxt_i is seen high with the command byte, there is one turnaround clock with the output enable low. The engine then samples ulpi_data_i on the next clock and allows one more turnaround clock. After that, vp_run_o clears and vp_rdata_o holds the sampled byte.
- R6: While ulpi_dir_i is high during the command phase, the engine releases the bus and ignores ulpi_nxt_i. It drives the command again once ulpi_dir_i falls.
- R7: A cmd_we_i pulse while vp_run_o=1 is ignored: the cycle in progress keeps its direction, address and data.
- R8: stop_force_i=1 holds ulpi_stp_o high on every clock. Clearing it returns STP to the sequencer's control.
- R9: stall_o rises once vp_run_o has been 1 for STALL_CYC consecutive clocks, and it is 0 whenever vp_run_o is 0.
- R10: link_rst_i returns the engine to idle with vp_run_o and stall_o cleared, and a following command runs normally.
- R11: Every requested read issues its own command byte on the bus. Two reads of the same address each complete, and each one updates vp_rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ULPI clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_rst_i | input | 1 | Synchronous link reset, aborts any transfer |
| cmd_we_i | input | 1 | Viewport write strobe |
| cmd_run_i | input | 1 | Run flag of the written word |
| cmd_rd_i | input | 1 | 1 = register read, 0 = register write |
| cmd_addr_i | input | 6 | Register address |
| cmd_wdata_i | input | 8 | Write byte |
| stop_force_i | input | 1 | Holds STP high while set |
| vp_run_o | output | 1 | Run flag, self-clearing |
| vp_rdata_o | output | 8 | Byte from the last read |
| stall_o | output | 1 | Run flag held for STALL_CYC clocks |
| ulpi_dir_i | input | 1 | Bus direction from the transceiver |
| ulpi_nxt_i | input | 1 | Throttle from the transceiver |
| ulpi_data_i | input | 8 | Data bus in |
| ulpi_data_o | output | 8 | Data bus out |
| ulpi_data_oe_o | output | 1 | Data bus output enable |
| ulpi_stp_o | output | 1 | STP line |

## Verification
Several properties are checked on every clock by the assertions: STP follows the stop-force control, the output enable stays low during read turnarounds, an accepted command raises the run flag, and a busy engine ignores new writes. They also check that the run flag only clears from a closing phase or a link reset, and that the stall flag never shows without the run flag. Other behaviour can only be shown by the bench's scenarios. This covers the exact phase timing of the command, data and turnaround clocks, the retry while the transceiver holds DIR, the captured read bytes across repeated reads, and the stall and link-reset recovery. All of these are compared clock by clock against a behavioural model.

// File: rtl/ulpi_vp_pkg.sv
package ulpi_vp_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WDAT, S_WSTP, S_TA1, S_RDAT, S_TA2
  } vp_state_e;

  localparam logic [1:0] TX_REGWR = 2'b10;
  localparam logic [1:0] TX_REGRD = 2'b11;
endpackage

// File: rtl/ulpi_vp_seq.sv
module ulpi_vp_seq
  import ulpi_vp_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_rst_i,
  input  logic              cmd_we_i,
  input  logic              cmd_run_i,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic              dir_i,
  input  logic              nxt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              stp_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o
);
  vp_state_e st_q, st_d;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              accept;

  assign accept = (st_q == S_IDLE) && cmd_we_i && cmd_run_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (accept) st_d = S_CMD;
      S_CMD:  if (!dir_i && nxt_i) st_d = rd_q ? S_TA1 : S_WDAT;
      S_WDAT: st_d = S_WSTP;
      S_WSTP: st_d = S_IDLE;
      S_TA1:  st_d = S_RDAT;
      S_RDAT: st_d = S_TA2;
      S_TA2:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      rdata_o <= '0;
    end else if (link_rst_i) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
      if (accept) begin
        rd_q   <= cmd_rd_i;
        addr_q <= cmd_addr_i;
        wd_q   <= cmd_wdata_i;
      end
      if (st_q == S_RDAT) rdata_o <= data_i;
    end
  end

  always_comb begin
    data_o    = '0;
    data_oe_o = 1'b0;
    unique case (st_q)
      S_CMD: if (!dir_i) begin
        data_oe_o = 1'b1;
        data_o    = {rd_q ? TX_REGRD : TX_REGWR, addr_q};
      end
      S_WDAT: begin data_oe_o = 1'b1; data_o = wd_q; end
      S_WSTP: data_oe_o = 1'b1;
      default: ;
    endcase
  end

  assign stp_o  = (st_q == S_WSTP);
  assign busy_o = (st_q != S_IDLE);

  p_turnaround_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_TA1 || st_q == S_TA2) |-> !data_oe_o);
  p_hold_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !link_rst_i) |=> ($stable(addr_q) && $stable(rd_q) && $stable(wd_q)));
  p_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(link_rst_i)) |-> ($past(st_q) == S_WSTP || $past(st_q) == S_TA2));
endmodule

// File: rtl/ulpi_vp_watch.sv
module ulpi_vp_watch #(
  parameter int STALL_CYC = 600000,
  localparam int CNT_W = $clog2(STALL_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic stall_o
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STALL_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign stall_o = run_i && (cnt_q == LIMIT);

  p_stall_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> run_i);
endmodule

// File: rtl/ulpi_vp_engine.sv
module ulpi_vp_engine #(
  parameter int DATA_W    = 8,
  parameter int STALL_CYC = 600000,
  localparam int ADDR_W   = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_rst_i,
  input  logic              cmd_we_i,
  input  logic              cmd_run_i,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic              stop_force_i,
  output logic              vp_run_o,
  output logic [DATA_W-1:0] vp_rdata_o,
  output logic              stall_o,
  input  logic              ulpi_dir_i,
  input  logic              ulpi_nxt_i,
  input  logic [DATA_W-1:0] ulpi_data_i,
  output logic [DATA_W-1:0] ulpi_data_o,
  output logic              ulpi_data_oe_o,
  output logic              ulpi_stp_o
);
  logic seq_stp;

  ulpi_vp_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .link_rst_i,
    .cmd_we_i, .cmd_run_i, .cmd_rd_i, .cmd_addr_i, .cmd_wdata_i,
    .dir_i(ulpi_dir_i), .nxt_i(ulpi_nxt_i), .data_i(ulpi_data_i),
    .data_o(ulpi_data_o), .data_oe_o(ulpi_data_oe_o), .stp_o(seq_stp),
    .busy_o(vp_run_o), .rdata_o(vp_rdata_o)
  );

  ulpi_vp_watch #(.STALL_CYC(STALL_CYC)) u_watch (
    .clk_i, .rst_ni, .run_i(vp_run_o), .stall_o
  );

  // suspend override wins over the sequencer
  assign ulpi_stp_o = seq_stp | stop_force_i;

  p_stop_force_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_force_i |-> ulpi_stp_o);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vp_run_o && cmd_we_i && cmd_run_i && !link_rst_i) |=> vp_run_o);
  p_link_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rst_i |=> (!vp_run_o && !stall_o));
endmodule

// File: tb/ulpi_vp_engine_bench.sv
module ulpi_vp_engine_bench;
  localparam int T = 20;
  logic clk_i = 0, rst_ni = 0, link_rst_i = 0;
  logic cmd_we_i = 0, cmd_run_i = 0, cmd_rd_i = 0, stop_force_i = 0;
  logic [5:0] cmd_addr_i = '0;
  logic [7:0] cmd_wdata_i = '0, ulpi_data_i = '0;
  logic ulpi_dir_i = 0, ulpi_nxt_i = 0;
  logic vp_run_o, stall_o, ulpi_data_oe_o, ulpi_stp_o;
  logic [7:0] vp_rdata_o, ulpi_data_o;

  ulpi_vp_engine #(.DATA_W(8), .STALL_CYC(T)) u_ulpi_vp_engine (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 cmd,2 wdata,3 wstop,4 ta1,5 sample,6 ta2
  int m_ph = 0, m_cnt = 0;
  bit m_run = 0, m_rd = 0;
  logic [5:0] m_addr = 0;
  logic [7:0] m_wd = 0, m_rdata = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_run = 0; m_rdata = 0;
    end else begin
      if (m_run && !link_rst_i) m_cnt = (m_cnt < T) ? m_cnt + 1 : T; else m_cnt = 0;
      if (link_rst_i) begin m_ph = 0; m_run = 0; end
      else case (m_ph)
        0: if (cmd_we_i && cmd_run_i) begin
             m_ph = 1; m_run = 1; m_rd = cmd_rd_i; m_addr = cmd_addr_i; m_wd = cmd_wdata_i;
           end
        1: if (!ulpi_dir_i && ulpi_nxt_i) m_ph = m_rd ? 4 : 2;
        2: m_ph = 3;
        3: begin m_ph = 0; m_run = 0; end
        4: m_ph = 5;
        5: begin m_rdata = ulpi_data_i; m_ph = 6; end
        6: begin m_ph = 0; m_run = 0; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !finished) begin
      automatic bit oe_e = (m_ph == 1 && !ulpi_dir_i) || m_ph == 2 || m_ph == 3;
      automatic logic [7:0] d_e = (m_ph == 1 && !ulpi_dir_i) ? {1'b1, m_rd, m_addr} :
                                  (m_ph == 2) ? m_wd : 8'h00;
      automatic bit stp_e = (m_ph == 3) || stop_force_i;
      chk(vp_run_o == m_run, "R2 run flag", vp_run_o, m_run);
      chk(ulpi_data_oe_o == oe_e, "R5 R6 output enable", ulpi_data_oe_o, oe_e);
      chk(ulpi_data_o == d_e, "R3 R4 bus data", ulpi_data_o, d_e);
      chk(ulpi_stp_o == stp_e, "R4 R8 stp", ulpi_stp_o, stp_e);
      chk(vp_rdata_o == m_rdata, "R5 R11 read data", vp_rdata_o, m_rdata);
      chk(stall_o == (m_run && m_cnt == T), "R9 stall", stall_o, (m_run && m_cnt == T));
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic issue(input bit rd, input logic [5:0] a, input logic [7:0] d, input bit run = 1);
    tick();
    cmd_we_i = 1; cmd_run_i = run; cmd_rd_i = rd; cmd_addr_i = a; cmd_wdata_i = d;
    tick();
    cmd_we_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      #2;
      if (!vp_run_o) break;
      tick();
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_ni = 1;
    #2;
    chk(!vp_run_o && !ulpi_data_oe_o && !ulpi_stp_o && !stall_o && vp_rdata_o == 0,
        "R1 reset state", {vp_run_o, ulpi_data_oe_o, ulpi_stp_o, stall_o}, 0);

    // R4 write with delayed nxt
    issue(0, 6'h0A, 8'h5C);
    #2 chk(ulpi_data_o == 8'h8A, "R3 write txcmd", ulpi_data_o, 8'h8A);
    tick(2); ulpi_nxt_i = 1; tick(); ulpi_nxt_i = 0;
    wait_idle();
    chk(!vp_run_o, "R4 write completes", vp_run_o, 0);

    // R5 read
    ulpi_data_i = 8'hA7;
    issue(1, 6'h14, 8'h00);
    #2 chk(ulpi_data_o == 8'hD4, "R3 read txcmd", ulpi_data_o, 8'hD4);
    ulpi_nxt_i = 1; tick(); ulpi_nxt_i = 0; ulpi_dir_i = 1; tick(2); ulpi_dir_i = 0;
    wait_idle();
    chk(vp_rdata_o == 8'hA7, "R5 read byte", vp_rdata_o, 8'hA7);

    // R11 repeat read of same address
    ulpi_data_i = 8'h3C;
    issue(1, 6'h14, 8'h00);
    ulpi_nxt_i = 1; tick(); ulpi_nxt_i = 0;
    wait_idle();
    chk(vp_rdata_o == 8'h3C, "R11 second read", vp_rdata_o, 8'h3C);

    // R6 dir high during command phase
    ulpi_dir_i = 1; ulpi_nxt_i = 1;
    issue(0, 6'h21, 8'hE1);
    tick(3);
    #2 chk(vp_run_o && !ulpi_data_oe_o, "R6 held off by dir", ulpi_data_oe_o, 0);
    ulpi_dir_i = 0; tick(); ulpi_nxt_i = 0;
    wait_idle();

    // R7 command while busy ignored
    ulpi_data_i = 8'h66;
    issue(1, 6'h02, 8'h00);
    issue(0, 6'h3F, 8'h99);
    ulpi_nxt_i = 1; tick(); ulpi_nxt_i = 0;
    wait_idle();
    chk(vp_rdata_o == 8'h66, "R7 busy write ignored", vp_rdata_o, 8'h66);

    // R2 run=0 starts nothing
    issue(0, 6'h05, 8'h11, 0);
    #2 chk(!vp_run_o, "R2 no run flag", vp_run_o, 0);

    // R8 stop force
    stop_force_i = 1; tick(3);
    #2 chk(ulpi_stp_o, "R8 forced stp", ulpi_stp_o, 1);
    stop_force_i = 0; tick();
    #2 chk(!ulpi_stp_o, "R8 released stp", ulpi_stp_o, 0);

    // R9 stall then R10 link reset
    issue(0, 6'h30, 8'h01);
    tick(T + 3);
    #2 chk(stall_o, "R9 stall raised", stall_o, 1);
    link_rst_i = 1; tick(); link_rst_i = 0;
    #2 chk(!vp_run_o && !stall_o, "R10 link reset", {vp_run_o, stall_o}, 0);
    issue(0, 6'h31, 8'h02);
    ulpi_nxt_i = 1; tick(); ulpi_nxt_i = 0;
    wait_idle();
    chk(!vp_run_o, "R10 command after link reset", vp_run_o, 0);

    tick(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule